// File: doc/BRIEF.md
# Erase/Program Suspend-Resume Controller

This block tracks nested long-running operations behind a byte-wide command interface of a flash-style memory. A command byte arrives with a write strobe and a target block index. The controller starts a block erase or a word program and then follows it to completion. It can suspend either operation and later resume it. While an erase is held, another block may be read or programmed. A program started in that window can be suspended in turn. An operation timer outside the block reports each completion with a one-cycle done pulse.

Read requests carry their own block index. The controller grants a read only when no operation is running, and never to a block whose operation is held. A refused read is flagged one cycle later. So is a program aimed at the block of the held erase. The index of the held erase block is presented on an output so that the surrounding logic can steer status reporting.

Top module: `susp_resume_ctrl`

## Requirements
- R1: A synchronous active-low reset puts the block in IDLE. After reset, `suspended`, `access_err` and `susp_blk` are 0. The state output codes are IDLE=0, ERASING=1, ERASE_SUSP=2, PROG_IN_ERASE_SUSP=3, PROGRAMMING=4 and PROG_SUSP=5.
- R2: A strobed byte 20h in IDLE enters ERASING on the next cycle. A strobed byte 40h in IDLE enters PROGRAMMING on the next cycle. In both cases the strobed block index is captured as the target.
- R3: A done pulse in ERASING or PROGRAMMING returns the block to IDLE. A done pulse in PROG_IN_ERASE_SUSP returns it to ERASE_SUSP, and the erase stays held there until a resume arrives. When a done pulse and a command arrive in the same cycle, the done pulse wins.
- R4: A strobed byte B0h in ERASING enters ERASE_SUSP on the next cycle. At that point `suspended` is 1 and `susp_blk` shows the erase target.
- R5: A strobed byte D0h in ERASE_SUSP re-enters ERASING on the next cycle, and `suspended` falls to 0.
- R6: While an erase is held (ERASE_SUSP, or PROG_SUSP entered from PROG_IN_ERASE_SUSP), a read of the erase target gives `access_ok`=0. `access_err` is then 1 for the next cycle. A read of any other block gives `access_ok`=1, unless R8 forbids it.
- R7: A strobed 40h in ERASE_SUSP to a block other than the erase target enters PROG_IN_ERASE_SUSP. A strobed 40h to the erase target leaves the state unchanged and raises `access_err` for the next cycle.
- R8: A strobed B0h in PROGRAMMING or PROG_IN_ERASE_SUSP enters PROG_SUSP. In PROG_SUSP a read of the program target is refused and raises `access_err` for the next cycle.
- R9: A strobed D0h in PROG_SUSP resumes the program. It goes to PROG_IN_ERASE_SUSP when an erase is held beneath it, and to PROGRAMMING otherwise.
- R10: A strobed D0h in IDLE, ERASING or PROGRAMMING leaves the state unchanged.
- R11: In ERASING, PROGRAMMING and PROG_IN_ERASE_SUSP every read gets `access_ok`=0 and raises `access_err` for the next cycle. In IDLE every read is granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_byte | input | 8 | Command byte |
| cmd_blk | input | BLK_W | Target block of the command |
| op_done | input | 1 | Completion pulse from the operation timer |
| rd_req | input | 1 | Read request |
| rd_blk | input | BLK_W | Block addressed by the read |
| state | output | 3 | Current controller state code |
| susp_blk | output | BLK_W | Block of the held erase, 0 when none |
| suspended | output | 1 | An operation is held |
| access_ok | output | 1 | Current read request is granted |
| access_err | output | 1 | A read or program was refused in the previous cycle |

## Verification
On every cycle, the checker confirms the following:
- Suspend and resume of an erase take effect one cycle after the strobe.
- A resume with nothing held leaves IDLE untouched.
- A completed nested program falls back to the held erase.
- A read of the held erase block is never granted and is always flagged.
- No grant is issued while an operation is running.

The bench's scenarios show the longer stories:
- The erase stays parked after its nested program completes.
- A program suspended on top of a held erase returns to the right state.
- Done-versus-command priority.
- The index shown on `susp_blk`.
- Recovery from a reset taken in the middle of a nested operation.

// File: rtl/flash_sr_pkg.sv
// Package: shared state codes and command byte values for the
// suspend-resume controller. Assumes an 8-bit command bus.
package flash_sr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_ERASING    = 3'd1,
        ST_ERASE_SUSP = 3'd2,
        ST_PROG_IN_ES = 3'd3,
        ST_PROGRAMMING= 3'd4,
        ST_PROG_SUSP  = 3'd5
    } sr_state_e;

    localparam logic [7:0] OP_ERASE  = 8'h20;
    localparam logic [7:0] OP_PROG   = 8'h40;
    localparam logic [7:0] OP_SUSP   = 8'hB0;
    localparam logic [7:0] OP_RESUME = 8'hD0;

    typedef struct packed {
        logic erase;
        logic prog;
        logic susp;
        logic resume;
    } sr_cmd_t;

endpackage

// File: rtl/sr_cmd_decode.sv
// Command decoder: turns a strobed command byte into one-hot request
// flags. Assumes the byte is valid in the cycle that cmd_we is high.
// Unknown bytes produce no request.
module sr_cmd_decode
    import flash_sr_pkg::*;
(
    input  logic        cmd_we,
    input  logic [7:0]  cmd_byte,
    output sr_cmd_t     cmd
);

    // Purpose: compare the byte against each known opcode under the strobe.
    always_comb begin
        cmd        = '0;
        cmd.erase  = cmd_we && (cmd_byte == OP_ERASE);
        cmd.prog   = cmd_we && (cmd_byte == OP_PROG);
        cmd.susp   = cmd_we && (cmd_byte == OP_SUSP);
        cmd.resume = cmd_we && (cmd_byte == OP_RESUME);
    end

endmodule

// File: rtl/sr_fsm.sv
// Sequencer: holds the operation state, the erase and program targets,
// and whether a suspended program sits on top of a held erase.
// Assumes op_done is a single-cycle pulse. The done pulse outranks
// any command that arrives in the same cycle.
module sr_fsm
    import flash_sr_pkg::*;
#(
    parameter int BLK_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sr_cmd_t          cmd,
    input  logic [BLK_W-1:0] cmd_blk,
    input  logic             op_done,
    output sr_state_e        state_q,
    output logic [BLK_W-1:0] erase_blk_q,
    output logic [BLK_W-1:0] prog_blk_q,
    output logic             erase_held
);

    sr_state_e state_d;
    logic      nested_q;

    // Purpose: an erase is held beneath the current state.
    always_comb begin
        erase_held = (state_q == ST_ERASE_SUSP) || (state_q == ST_PROG_IN_ES) ||
                     ((state_q == ST_PROG_SUSP) && nested_q);
    end

    // Purpose: next-state selection from commands and completion.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd.erase)     state_d = ST_ERASING;
                else if (cmd.prog) state_d = ST_PROGRAMMING;
            end
            ST_ERASING: begin
                if (op_done)       state_d = ST_IDLE;
                else if (cmd.susp) state_d = ST_ERASE_SUSP;
            end
            ST_ERASE_SUSP: begin
                if (cmd.resume)    state_d = ST_ERASING;
                else if (cmd.prog && (cmd_blk != erase_blk_q))
                                   state_d = ST_PROG_IN_ES;
            end
            ST_PROG_IN_ES: begin
                if (op_done)       state_d = ST_ERASE_SUSP;
                else if (cmd.susp) state_d = ST_PROG_SUSP;
            end
            ST_PROGRAMMING: begin
                if (op_done)       state_d = ST_IDLE;
                else if (cmd.susp) state_d = ST_PROG_SUSP;
            end
            ST_PROG_SUSP: begin
                if (cmd.resume)    state_d = nested_q ? ST_PROG_IN_ES : ST_PROGRAMMING;
            end
            default:               state_d = ST_IDLE;
        endcase
    end

    // Purpose: state register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Purpose: capture operation targets when an operation starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_blk_q <= '0;
            prog_blk_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && state_d == ST_ERASING)
                erase_blk_q <= cmd_blk;
            if (state_d == ST_PROGRAMMING && state_q == ST_IDLE)
                prog_blk_q <= cmd_blk;
            if (state_d == ST_PROG_IN_ES && state_q == ST_ERASE_SUSP)
                prog_blk_q <= cmd_blk;
        end
    end

    // Purpose: remember whether a program suspend was taken over a held erase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nested_q <= 1'b0;
        else if (state_d == ST_PROG_SUSP && state_q != ST_PROG_SUSP)
            nested_q <= (state_q == ST_PROG_IN_ES);
    end

endmodule

// File: rtl/sr_access_gate.sv
// Access gate: grants reads against the current state and the held
// targets, and registers a one-cycle error for any refused read or
// refused program. Assumes the targets are stable while held.
module sr_access_gate
    import flash_sr_pkg::*;
#(
    parameter int BLK_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sr_state_e        state_q,
    input  logic             erase_held,
    input  logic [BLK_W-1:0] erase_blk_q,
    input  logic [BLK_W-1:0] prog_blk_q,
    input  logic             rd_req,
    input  logic [BLK_W-1:0] rd_blk,
    input  logic             prog_cmd,
    input  logic [BLK_W-1:0] cmd_blk,
    output logic             grant,
    output logic             err_q
);

    logic quiet_state;
    logic hit_erase;
    logic hit_prog;
    logic prog_refused;

    // Purpose: decide whether the addressed block may be read now.
    always_comb begin
        quiet_state  = (state_q == ST_IDLE) || (state_q == ST_ERASE_SUSP) ||
                       (state_q == ST_PROG_SUSP);
        hit_erase    = erase_held && (rd_blk == erase_blk_q);
        hit_prog     = (state_q == ST_PROG_SUSP) && (rd_blk == prog_blk_q);
        grant        = rd_req && quiet_state && !hit_erase && !hit_prog;
        prog_refused = prog_cmd && (state_q == ST_ERASE_SUSP) && (cmd_blk == erase_blk_q);
    end

    // Purpose: one-cycle error flag for a refused request.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= (rd_req && !grant) || prog_refused;
    end

endmodule

// File: rtl/susp_resume_ctrl.sv
// Top: suspend-resume controller for a flash-style command interface.
// It decodes commands, sequences erase/program with nested suspend, and
// gates reads per block. Assumes a single clock domain and a synchronous
// active-low reset. Assumes at most one operation timer reports done.
module susp_resume_ctrl
    import flash_sr_pkg::*;
#(
    parameter int BLK_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [7:0]       cmd_byte,
    input  logic [BLK_W-1:0] cmd_blk,
    input  logic             op_done,
    input  logic             rd_req,
    input  logic [BLK_W-1:0] rd_blk,
    output logic [2:0]       state,
    output logic [BLK_W-1:0] susp_blk,
    output logic             suspended,
    output logic             access_ok,
    output logic             access_err
);

    sr_cmd_t          cmd;
    sr_state_e        state_q;
    logic [BLK_W-1:0] erase_blk_q;
    logic [BLK_W-1:0] prog_blk_q;
    logic             erase_held;

    sr_cmd_decode u_dec (
        .cmd_we   (cmd_we),
        .cmd_byte (cmd_byte),
        .cmd      (cmd)
    );

    sr_fsm #(.BLK_W(BLK_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd),
        .cmd_blk     (cmd_blk),
        .op_done     (op_done),
        .state_q     (state_q),
        .erase_blk_q (erase_blk_q),
        .prog_blk_q  (prog_blk_q),
        .erase_held  (erase_held)
    );

    sr_access_gate #(.BLK_W(BLK_W)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_q     (state_q),
        .erase_held  (erase_held),
        .erase_blk_q (erase_blk_q),
        .prog_blk_q  (prog_blk_q),
        .rd_req      (rd_req),
        .rd_blk      (rd_blk),
        .prog_cmd    (cmd.prog),
        .cmd_blk     (cmd_blk),
        .grant       (access_ok),
        .err_q       (access_err)
    );

    // Purpose: present state code, held flag and held erase block.
    always_comb begin
        state     = state_q;
        suspended = (state_q == ST_ERASE_SUSP) || (state_q == ST_PROG_IN_ES) ||
                    (state_q == ST_PROG_SUSP);
        susp_blk  = erase_held ? erase_blk_q : '0;
    end

endmodule

// File: rtl/susp_resume_ctrl_chk.sv
// Checker: temporal properties of the suspend-resume controller,
// observed at its ports. Bound into every instance of the top.
module susp_resume_ctrl_chk #(
    parameter int BLK_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_we,
    input logic [7:0]       cmd_byte,
    input logic [BLK_W-1:0] cmd_blk,
    input logic             op_done,
    input logic             rd_req,
    input logic [BLK_W-1:0] rd_blk,
    input logic [2:0]       state,
    input logic [BLK_W-1:0] susp_blk,
    input logic             suspended,
    input logic             access_ok,
    input logic             access_err
);

    assert_legal_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        state <= 3'd5);

    assert_erase_suspend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_byte == 8'hB0 && state == 3'd1 && !op_done)
        |=> (state == 3'd2 && suspended));

    assert_erase_resume_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_byte == 8'hD0 && state == 3'd2) |=> (state == 3'd1 && !suspended));

    assert_nested_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd3 && op_done) |=> (state == 3'd2));

    assert_held_block_denied_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && state == 3'd2 && rd_blk == susp_blk) |-> !access_ok);

    assert_held_block_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && state == 3'd2 && rd_blk == susp_blk) |=> access_err);

    assert_idle_resume_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_byte == 8'hD0 && state == 3'd0) |=> (state == 3'd0));

    assert_busy_no_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd1 || state == 3'd3 || state == 3'd4) |-> !access_ok);

endmodule

bind susp_resume_ctrl susp_resume_ctrl_chk #(.BLK_W(BLK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_we     (cmd_we),
    .cmd_byte   (cmd_byte),
    .cmd_blk    (cmd_blk),
    .op_done    (op_done),
    .rd_req     (rd_req),
    .rd_blk     (rd_blk),
    .state      (state),
    .susp_blk   (susp_blk),
    .suspended  (suspended),
    .access_ok  (access_ok),
    .access_err (access_err)
);

// File: tb/susp_resume_ctrl_tb.sv
module susp_resume_ctrl_tb;

    localparam int BLK_W = 4;

    typedef struct packed {
        logic       we;
        logic [7:0] cmd;
        logic [3:0] blk;
        logic       done;
        logic       rd;
        logic [3:0] rblk;
        logic       ok;
        logic [2:0] st;
        logic       susp;
        logic       err;
    } vec_t;

    function automatic vec_t mk(logic we, logic [7:0] c, logic [3:0] b, logic d,
                                logic r, logic [3:0] rb, logic ok, logic [2:0] st,
                                logic su, logic er);
        vec_t v;
        v.we = we; v.cmd = c; v.blk = b; v.done = d; v.rd = r; v.rblk = rb;
        v.ok = ok; v.st = st; v.susp = su; v.err = er;
        return v;
    endfunction

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        mk(1, 8'hD0, 0, 0, 1, 2, 1, 0, 0, 0), // R10 resume in IDLE, R11 idle read
        mk(1, 8'h20, 5, 0, 0, 0, 0, 1, 0, 0), // R2 erase start
        mk(0, 8'h00, 0, 0, 1, 2, 0, 1, 0, 1), // R11 read while erasing
        mk(1, 8'hD0, 0, 0, 0, 0, 0, 1, 0, 0), // R10 resume while erasing
        mk(1, 8'hB0, 0, 0, 0, 0, 0, 2, 1, 0), // R4 suspend erase
        mk(0, 8'h00, 0, 0, 1, 5, 0, 2, 1, 1), // R6 read held block
        mk(0, 8'h00, 0, 0, 1, 3, 1, 2, 1, 0), // R6 read other block
        mk(1, 8'h40, 5, 0, 0, 0, 0, 2, 1, 1), // R7 program held block
        mk(1, 8'h40, 7, 0, 0, 0, 0, 3, 1, 0), // R7 program other block
        mk(1, 8'hB0, 0, 0, 0, 0, 0, 5, 1, 0), // R8 suspend nested program
        mk(0, 8'h00, 0, 0, 1, 7, 0, 5, 1, 1), // R8 read program block
        mk(0, 8'h00, 0, 0, 1, 5, 0, 5, 1, 1), // R6 erase still held
        mk(0, 8'h00, 0, 0, 1, 1, 1, 5, 1, 0), // R8 read other block
        mk(1, 8'hD0, 0, 0, 0, 0, 0, 3, 1, 0), // R9 resume to nested program
        mk(0, 8'h00, 0, 1, 0, 0, 0, 2, 1, 0), // R3 nested done
        mk(0, 8'h00, 0, 0, 0, 0, 0, 2, 1, 0), // R3 erase stays held
        mk(1, 8'hD0, 0, 0, 0, 0, 0, 1, 0, 0), // R5 resume erase
        mk(0, 8'h00, 0, 1, 0, 0, 0, 0, 0, 0), // R3 erase done
        mk(1, 8'h40, 4, 0, 0, 0, 0, 4, 0, 0), // R2 program start
        mk(1, 8'hD0, 0, 0, 0, 0, 0, 4, 0, 0), // R10 resume while programming
        mk(1, 8'hB0, 0, 0, 0, 0, 0, 5, 1, 0), // R8 suspend program
        mk(0, 8'h00, 0, 0, 1, 4, 0, 5, 1, 1), // R8 read program block
        mk(1, 8'hD0, 0, 0, 0, 0, 0, 4, 0, 0), // R9 resume plain program
        mk(1, 8'hB0, 0, 1, 0, 0, 0, 0, 0, 0)  // R3 done beats suspend
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_we = 1'b0;
    logic [7:0]       cmd_byte = '0;
    logic [BLK_W-1:0] cmd_blk = '0;
    logic             op_done = 1'b0;
    logic             rd_req = 1'b0;
    logic [BLK_W-1:0] rd_blk = '0;
    logic [2:0]       state;
    logic [BLK_W-1:0] susp_blk;
    logic             suspended;
    logic             access_ok;
    logic             access_err;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    susp_resume_ctrl #(.BLK_W(BLK_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_we     (cmd_we),
        .cmd_byte   (cmd_byte),
        .cmd_blk    (cmd_blk),
        .op_done    (op_done),
        .rd_req     (rd_req),
        .rd_blk     (rd_blk),
        .state      (state),
        .susp_blk   (susp_blk),
        .suspended  (suspended),
        .access_ok  (access_ok),
        .access_err (access_err)
    );

    task automatic check(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(logic we, logic [7:0] c, logic [3:0] b, logic d,
                         logic r, logic [3:0] rb);
        @(negedge clk);
        cmd_we = we; cmd_byte = c; cmd_blk = b; op_done = d; rd_req = r; rd_blk = rb;
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
        cmd_we = 0; op_done = 0; rd_req = 0;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 state after reset", state, 0);
        check("R1 suspended after reset", suspended, 0);
        check("R1 err after reset", access_err, 0);
        check("R1 susp_blk after reset", susp_blk, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].we, VEC[i].cmd, VEC[i].blk, VEC[i].done, VEC[i].rd, VEC[i].rblk);
            #1;
            check($sformatf("vec%0d access_ok (R6/R8/R11)", i), access_ok, VEC[i].ok);
            settle();
            check($sformatf("vec%0d state (R2-R10)", i), state, VEC[i].st);
            check($sformatf("vec%0d suspended (R4/R5)", i), suspended, VEC[i].susp);
            check($sformatf("vec%0d access_err (R6/R7/R8)", i), access_err, VEC[i].err);
        end

        // R4: held erase block shown on susp_blk
        drive(1, 8'h20, 9, 0, 0, 0); settle();
        drive(1, 8'hB0, 0, 0, 0, 0); settle();
        check("R4 susp_blk shows erase target", susp_blk, 9);
        // R6: susp_blk kept under a nested suspended program
        drive(1, 8'h40, 2, 0, 0, 0); settle();
        drive(1, 8'hB0, 0, 0, 0, 0); settle();
        check("R6 susp_blk under nested suspend", susp_blk, 9);
        check("R8 state nested suspend", state, 5);
        // R10: unknown byte in PROG_SUSP is ignored
        drive(1, 8'h55, 0, 0, 0, 0); settle();
        check("R10 unknown byte ignored", state, 5);
        // R6: access_err lasts one cycle
        drive(0, 8'h00, 0, 0, 1, 9); settle();
        check("R6 err raised", access_err, 1);
        drive(0, 8'h00, 0, 0, 0, 0); settle();
        check("R6 err clears", access_err, 0);

        // R1: reset in the middle of a nested operation
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1 state after mid-op reset", state, 0);
        check("R1 susp_blk after mid-op reset", susp_blk, 0);
        check("R1 suspended after mid-op reset", suspended, 0);
        @(negedge clk); rst_n = 1'b1;
        // R9: after reset, a new program resumes plainly
        drive(1, 8'h40, 3, 0, 0, 0); settle();
        drive(1, 8'hB0, 0, 0, 0, 0); settle();
        drive(1, 8'hD0, 0, 0, 0, 0); settle();
        check("R9 resume without erase beneath", state, 4);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule